// File: doc/BRIEF.md
# Descriptor Chain Engine for One DMA Channel

This block is the control engine of a single DMA channel that moves a sequence of buffers described by a chain of descriptors in memory. Each descriptor is five words, placed at consecutive word offsets from its base:

| Offset | Word |
|--------|------|
| 0x0 | source address |
| 0x4 | destination address |
| 0x8 | pointer to the next descriptor |
| 0xC | primary control word |
| 0x10 | secondary control word |

Once the channel is enabled, the engine reads the descriptor at the starting pointer and loads its working registers. It then hands the buffer to a transfer engine through a request/done handshake.

When the buffer ends, the engine writes only the primary control word back to its original location. That word carries the residual size reported by the transfer engine and has its done flag set, so software can poll completion in memory. The engine then follows the next pointer. A zero pointer ends the chain and raises a chain-done flag.

The memory side is a single request/acknowledge port shared by reads and writes. Dropping the channel enable part-way through a chain stops the engine cleanly: it stops only after the writeback of the buffer in progress.

Top module: `lli_chain_engine`

## Requirements
- R1: The engine leaves idle only when `globalEn` and `chanEn` are both 1 on a clock edge. `busy` goes to 1 in the following cycle and stays 0 while either enable is 0.
- R2: The first read of a chain uses `descPtrInit` with its two low bits forced to 0.
- R3: A descriptor fetch is five reads, at offsets 0x0, 0x4, 0x8, 0xC and 0x10 from the descriptor base and in that order. Each read completes on one `memAck`. The word at offset 0x0 appears on no output.
- R4: After the fifth read, `xferReq` stays 1 until `xferDone`. Throughout that time the transfer outputs are: `xferDst` = word 0x4, `xferCtrlA` = word 0xC, `xferCtrlB` = word 0x10.
- R5: After `xferDone` the engine makes exactly one write, at base+0xC. The written word is word 0xC with two changes: bits [15:0] are replaced by `xferSize`, and bit 31 (done) is set. No other write ever occurs.
- R6: When the write completes and the next pointer (word 0x8, low two bits forced to 0) is non-zero, the engine fetches the descriptor at that pointer.
- R7: When the next pointer is zero, the engine returns to idle and `chainDone` goes to 1. `chainDone` stays 1 until the next chain starts.
- R8: If an enable is 0 when the writeback completes, the engine goes idle after that writeback. It issues no further read and leaves `chainDone` at 0.
- R9: While `memReq` is 1 and `memAck` is 0, `memAddr`, `memWe` and `memWdata` hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| globalEn | input | 1 | Controller-wide enable |
| chanEn | input | 1 | Channel enable |
| descPtrInit | input | ADDR_W | Address of the first descriptor |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | 1 = write, 0 = read |
| memAddr | output | ADDR_W | Byte address of the access |
| memWdata | output | DATA_W | Write data |
| memRdata | input | DATA_W | Read data, valid with memAck |
| memAck | input | 1 | Access accepted this cycle |
| xferReq | output | 1 | Buffer transfer requested |
| xferDst | output | ADDR_W | Destination start of the buffer |
| xferCtrlA | output | DATA_W | Primary control word of the buffer |
| xferCtrlB | output | DATA_W | Secondary control word of the buffer |
| xferDone | input | 1 | Buffer finished (one-cycle pulse) |
| xferSize | input | SIZE_W | Residual size reported at xferDone |
| busy | output | 1 | Engine not idle |
| chainDone | output | 1 | Chain ended on a zero pointer |

## Verification
A wrong phase or word index inside the engine shows up on `memAddr` or `memWe` in the very next cycle the memory port is active. Such a fault produces a read at the wrong offset or a write where a read belongs, so it is caught on the next clock when compared against a behavioural model. A wrong captured pointer or control word appears either on the transfer outputs while `xferReq` is high, or in the address of the following fetch. A lost or duplicated writeback shows up in memory contents and in the write count at the end of the chain, a few hundred cycles later at most.

// File: rtl/lli_pkg.sv
package lli_pkg;

  localparam int DESC_WORDS = 5;
  localparam int IDX_W      = $clog2(DESC_WORDS);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_XFER,
    ST_WBACK,
    ST_NEXT
  } chainState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic             loadBase;    // take the initial pointer
    logic             followNext;  // take the captured next pointer
    logic             capWord;     // a read word is valid
    logic [IDX_W-1:0] wordSel;     // which descriptor word
    logic             capSize;     // merge residual size and done flag
    logic             addrWb;      // address the control word for writeback
  } chainStrb_t;

endpackage

// File: rtl/lli_ctrl.sv
module lli_ctrl
  import lli_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       globalEn,
  input  logic       chanEn,
  input  logic       memAck,
  input  logic       xferDone,
  input  logic       nextIsZero,
  output chainStrb_t strb,
  output logic       memReq,
  output logic       memWe,
  output logic       xferReq,
  output logic       busy,
  output logic       chainDone
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DESC_WORDS - 1);

  chainState_e state, stateNxt;
  logic [IDX_W-1:0] idx;
  logic runOk;

  assign runOk = globalEn & chanEn;

  always_comb begin
    stateNxt = state;
    case (state)
      ST_IDLE:  if (runOk) stateNxt = ST_FETCH;
      ST_FETCH: if (memAck && idx == LAST_IDX) stateNxt = ST_XFER;
      ST_XFER:  if (xferDone) stateNxt = ST_WBACK;
      ST_WBACK: if (memAck) stateNxt = ST_NEXT;
      ST_NEXT:  stateNxt = (nextIsZero || !runOk) ? ST_IDLE : ST_FETCH;
      default:  stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      idx       <= '0;
      chainDone <= 1'b0;
    end else begin
      state <= stateNxt;
      if (state == ST_IDLE && runOk) begin
        chainDone <= 1'b0;
        idx       <= '0;
      end
      if (state == ST_FETCH && memAck && idx != LAST_IDX) idx <= idx + 1'b1;
      if (state == ST_NEXT) begin
        idx <= '0;
        if (nextIsZero) chainDone <= 1'b1;
      end
    end
  end

  always_comb begin
    strb.loadBase   = (state == ST_IDLE) && runOk;
    strb.followNext = (state == ST_NEXT) && !nextIsZero && runOk;
    strb.capWord    = (state == ST_FETCH) && memAck;
    strb.wordSel    = idx;
    strb.capSize    = (state == ST_XFER) && xferDone;
    strb.addrWb     = (state == ST_WBACK);
  end

  assign memReq  = (state == ST_FETCH) || (state == ST_WBACK);
  assign memWe   = (state == ST_WBACK);
  assign xferReq = (state == ST_XFER);
  assign busy    = (state != ST_IDLE);

  assert_start_needs_enable_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(globalEn && chanEn));

  assert_xfer_held_R4: assert property (@(posedge clk) disable iff (!rstN)
    xferReq && !xferDone |=> xferReq);

  assert_write_after_done_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWe) |-> $past(xferDone));

  assert_chain_done_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    chainDone |-> !busy);

endmodule

// File: rtl/lli_dpath.sv
module lli_dpath
  import lli_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int SIZE_W   = 16,
  parameter int DONE_BIT = 31
) (
  input  logic              clk,
  input  logic              rstN,
  input  chainStrb_t        strb,
  input  logic [ADDR_W-1:0] descPtrInit,
  input  logic [DATA_W-1:0] memRdata,
  input  logic [SIZE_W-1:0] xferSize,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic [ADDR_W-1:0] xferDst,
  output logic [DATA_W-1:0] xferCtrlA,
  output logic [DATA_W-1:0] xferCtrlB,
  output logic              nextIsZero
);

  localparam int WORD_BYTES = DATA_W / 8;
  localparam int ALIGN_BITS = $clog2(WORD_BYTES);
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~((ADDR_W'(1) << ALIGN_BITS) - ADDR_W'(1));
  localparam logic [ADDR_W-1:0] CTRLA_OFF  = ADDR_W'(3 * WORD_BYTES);
  localparam logic [DATA_W-1:0] SIZE_MASK  = (DATA_W'(1) << SIZE_W) - DATA_W'(1);
  localparam logic [DATA_W-1:0] DONE_MASK  = DATA_W'(1) << DONE_BIT;

  logic [ADDR_W-1:0] descBase;
  logic [ADDR_W-1:0] nextPtr;
  logic [DATA_W-1:0] ctrlA;
  logic [ADDR_W-1:0] wordOff;
  logic [ADDR_W-1:0] rdAsAddr;

  assign rdAsAddr = ADDR_W'(memRdata);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      descBase  <= '0;
      nextPtr   <= '0;
      xferDst   <= '0;
      ctrlA     <= '0;
      xferCtrlB <= '0;
    end else begin
      if (strb.loadBase)   descBase <= descPtrInit & ALIGN_MASK;
      if (strb.followNext) descBase <= nextPtr;
      if (strb.capWord) begin
        case (strb.wordSel)
          IDX_W'(1): xferDst   <= rdAsAddr;
          IDX_W'(2): nextPtr   <= rdAsAddr & ALIGN_MASK;
          IDX_W'(3): ctrlA     <= memRdata;
          IDX_W'(4): xferCtrlB <= memRdata;
          default: ;  // source address word is not used
        endcase
      end
      if (strb.capSize) ctrlA <= (ctrlA & ~SIZE_MASK) | DATA_W'(xferSize) | DONE_MASK;
    end
  end

  assign wordOff    = ADDR_W'(strb.wordSel) << ALIGN_BITS;
  assign memAddr    = descBase + (strb.addrWb ? CTRLA_OFF : wordOff);
  assign memWdata   = ctrlA;
  assign xferCtrlA  = ctrlA;
  assign nextIsZero = (nextPtr == '0);

  assert_fetch_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.capWord && strb.wordSel < IDX_W'(DESC_WORDS - 1)
      |=> memAddr == $past(memAddr) + ADDR_W'(WORD_BYTES));

endmodule

// File: rtl/lli_chain_engine.sv
module lli_chain_engine
  import lli_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int SIZE_W   = 16,
  parameter int DONE_BIT = 31
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              globalEn,
  input  logic              chanEn,
  input  logic [ADDR_W-1:0] descPtrInit,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              memAck,
  output logic              xferReq,
  output logic [ADDR_W-1:0] xferDst,
  output logic [DATA_W-1:0] xferCtrlA,
  output logic [DATA_W-1:0] xferCtrlB,
  input  logic              xferDone,
  input  logic [SIZE_W-1:0] xferSize,
  output logic              busy,
  output logic              chainDone
);

  chainStrb_t strb;
  logic nextIsZero;

  lli_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .globalEn   (globalEn),
    .chanEn     (chanEn),
    .memAck     (memAck),
    .xferDone   (xferDone),
    .nextIsZero (nextIsZero),
    .strb       (strb),
    .memReq     (memReq),
    .memWe      (memWe),
    .xferReq    (xferReq),
    .busy       (busy),
    .chainDone  (chainDone)
  );

  lli_dpath #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .SIZE_W   (SIZE_W),
    .DONE_BIT (DONE_BIT)
  ) dpath_i (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .descPtrInit (descPtrInit),
    .memRdata    (memRdata),
    .xferSize    (xferSize),
    .memAddr     (memAddr),
    .memWdata    (memWdata),
    .xferDst     (xferDst),
    .xferCtrlA   (xferCtrlA),
    .xferCtrlB   (xferCtrlB),
    .nextIsZero  (nextIsZero)
  );

  assert_req_stable_R9: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq && $stable(memAddr) && $stable(memWe) && $stable(memWdata));

  assert_wb_done_set_R5: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memWe |-> memWdata[DONE_BIT]);

endmodule

// File: tb/lli_chain_engine_tb_top.sv
module lli_chain_engine_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        globalEn = 1'b0, chanEn = 1'b0;
  logic [31:0] descPtrInit = '0;
  logic        memReq, memWe, memAck = 1'b0;
  logic [31:0] memAddr, memWdata, memRdata = '0;
  logic        xferReq, xferDone = 1'b0;
  logic [31:0] xferDst, xferCtrlA, xferCtrlB;
  logic [15:0] xferSize = '0;
  logic        busy, chainDone;

  always #(CLK_PERIOD/2) clk = ~clk;

  lli_chain_engine dut_i (
    .clk(clk), .rstN(rstN), .globalEn(globalEn), .chanEn(chanEn),
    .descPtrInit(descPtrInit), .memReq(memReq), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata),
    .memAck(memAck), .xferReq(xferReq), .xferDst(xferDst),
    .xferCtrlA(xferCtrlA), .xferCtrlB(xferCtrlB), .xferDone(xferDone),
    .xferSize(xferSize), .busy(busy), .chainDone(chainDone)
  );

  int errors = 0, checks = 0, cycles = 0, wrCount = 0, bufCount = 0;
  int ackWait = 0, xWait = 0;
  bit finished = 0;
  logic [31:0] mem [0:255];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  function automatic int widx(input logic [31:0] a);
    return int'(a[9:2]);
  endfunction

  // behavioural reference: phase 0 idle, 1 reading, 2 moving, 3 writing, 4 deciding
  int mPhase = 0, mIdx = 0;
  logic [31:0] mBase = 0, mDst = 0, mNext = 0, mCtlA = 0, mCtlB = 0;
  bit mDone = 0;

  always @(posedge clk) begin
    cycles++;
    if (!rstN) begin
      mPhase = 0; mIdx = 0; mDone = 0;
      mBase = 0; mDst = 0; mNext = 0; mCtlA = 0; mCtlB = 0;
    end else begin
      case (mPhase)
        0: if (globalEn && chanEn) begin
             mBase = descPtrInit & ~32'h3; mIdx = 0; mDone = 0; mPhase = 1;
           end
        1: if (memAck) begin
             logic [31:0] w;
             w = mem[widx(mBase + 32'(4*mIdx))];
             if (mIdx == 1) mDst = w;
             if (mIdx == 2) mNext = w & ~32'h3;
             if (mIdx == 3) mCtlA = w;
             if (mIdx == 4) mCtlB = w;
             if (mIdx == 4) mPhase = 2; else mIdx++;
           end
        2: if (xferDone) begin
             mCtlA = (mCtlA & 32'hFFFF_0000) | {16'h0, xferSize} | 32'h8000_0000;
             mPhase = 3;
           end
        3: if (memAck) mPhase = 4;
        default: begin
          if (mNext == 0) begin mPhase = 0; mDone = 1; end
          else if (!(globalEn && chanEn)) mPhase = 0;
          else begin mBase = mNext; mIdx = 0; mPhase = 1; end
        end
      endcase
    end
  end

  // compare on every cycle, then drive memory and transfer responses
  always @(negedge clk) begin
    if (rstN && !finished) begin
      chk("R1 busy", 32'(busy), 32'(mPhase != 0));
      chk("R9 memReq", 32'(memReq), 32'(mPhase == 1 || mPhase == 3));
      chk("R5 memWe", 32'(memWe), 32'(mPhase == 3));
      if (mPhase == 1) chk("R3 read address", memAddr, mBase + 32'(4*mIdx));
      if (mPhase == 3) begin
        chk("R5 write address", memAddr, mBase + 32'hC);
        chk("R5 write data", memWdata, mCtlA);
      end
      chk("R4 xferReq", 32'(xferReq), 32'(mPhase == 2));
      if (mPhase == 2) begin
        chk("R4 xferDst", xferDst, mDst);
        chk("R4 xferCtrlA", xferCtrlA, mCtlA);
        chk("R4 xferCtrlB", xferCtrlB, mCtlB);
      end
      chk("R7 chainDone", 32'(chainDone), 32'(mDone));
    end
    memAck = 1'b0;
    if (memReq && rstN) begin
      if (ackWait == 0) begin
        memAck = 1'b1;
        memRdata = mem[widx(memAddr)];
        if (memWe) begin mem[widx(memAddr)] = memWdata; wrCount++; end
        ackWait = cycles % 3;
      end else ackWait--;
    end
    xferDone = 1'b0;
    if (xferReq && rstN) begin
      if (xWait == 0) begin
        xferDone = 1'b1;
        xferSize = 16'h00A0 + 16'(bufCount);
        bufCount++;
        xWait = 4;
      end else xWait--;
    end
  end

  task automatic setDesc(input logic [31:0] b, input logic [31:0] nx, input logic [31:0] ca);
    mem[widx(b)]        = 32'h5A5A_0000 | b;
    mem[widx(b + 4)]    = 32'h0080_0000 | b;
    mem[widx(b + 8)]    = nx;
    mem[widx(b + 32'hC)]  = ca;
    mem[widx(b + 32'h10)] = 32'hC0DE_0000 | b;
  endtask

  task automatic waitDone(output bit ok);
    ok = 0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (chainDone) begin ok = 1; break; end
    end
  endtask

  function automatic logic [31:0] wbExp(input logic [31:0] ca, input int n);
    return (ca & 32'hFFFF_0000) | 32'(16'h00A0 + 16'(n)) | 32'h8000_0000;
  endfunction

  initial begin
    bit ok;
    int b0, w0;
    for (int i = 0; i < 256; i++) mem[i] = 32'hDEAD_0000 | i;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 reset busy", 32'(busy), 0);
    chk("R1 reset memReq", 32'(memReq), 0);
    chk("R7 reset chainDone", 32'(chainDone), 0);

    // three-descriptor chain, misaligned pointers
    setDesc(32'h100, 32'h201, 32'h0000_1111);
    setDesc(32'h200, 32'h142, 32'h0000_2222);
    setDesc(32'h140, 32'h0,   32'h7000_3333);
    b0 = bufCount; w0 = wrCount;
    descPtrInit = 32'h103;
    globalEn = 1'b1; chanEn = 1'b1;
    @(negedge clk);
    chk("R2 first read address", memAddr, 32'h100);
    waitDone(ok);
    chanEn = 1'b0;
    chk("R7 chain ended", 32'(ok), 1);
    chk("R6 writes in chain", 32'(wrCount - w0), 3);
    chk("R5 wb desc0", mem[widx(32'h10C)], wbExp(32'h0000_1111, b0));
    chk("R6 wb desc1", mem[widx(32'h20C)], wbExp(32'h0000_2222, b0 + 1));
    chk("R6 wb desc2", mem[widx(32'h14C)], wbExp(32'h7000_3333, b0 + 2));
    chk("R3 source word untouched", mem[widx(32'h100)], 32'h5A5A_0100);
    repeat (5) @(negedge clk);
    chk("R7 chainDone holds", 32'(chainDone), 1);

    // global enable low keeps the channel idle
    globalEn = 1'b0; chanEn = 1'b1;
    descPtrInit = 32'h1C0;
    setDesc(32'h1C0, 32'h0, 32'h0000_4444);
    repeat (10) @(negedge clk);
    chk("R1 idle without global enable", 32'(busy), 0);
    b0 = bufCount;
    globalEn = 1'b1;
    @(negedge clk);
    chk("R1 starts with both enables", 32'(busy), 1);
    chk("R7 cleared on start", 32'(chainDone), 0);
    waitDone(ok);
    chanEn = 1'b0;
    chk("R7 single descriptor ends", 32'(ok), 1);
    chk("R5 single wb", mem[widx(32'h1CC)], wbExp(32'h0000_4444, b0));

    // disable in the middle of a chain
    repeat (3) @(negedge clk);
    setDesc(32'h300, 32'h340, 32'h0000_5555);
    setDesc(32'h340, 32'h380, 32'h0000_6666);
    setDesc(32'h380, 32'h0,   32'h0000_7777);
    descPtrInit = 32'h300; w0 = wrCount;
    chanEn = 1'b1;
    for (int i = 0; i < 500; i++) begin @(negedge clk); if (xferReq) break; end
    chanEn = 1'b0;
    for (int i = 0; i < 500; i++) begin @(negedge clk); if (!busy) break; end
    repeat (5) @(negedge clk);
    chk("R8 stopped", 32'(busy), 0);
    chk("R8 one writeback", 32'(wrCount - w0), 1);
    chk("R8 no chainDone", 32'(chainDone), 0);
    chk("R8 next descriptor untouched", mem[widx(32'h34C)], 32'h0000_6666);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    if (cycles > WATCHDOG && !finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=<%0d cycles", cycles, WATCHDOG);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule